// File: doc/BRIEF.md
# Horizontal Drive Generator with Lock and Flyback Supervision

This block produces the horizontal drive pulse for a display deflection stage from a digital line-position counter. The counter covers one line in two halves, so the block's internal timing runs at twice the line rate. The host chooses one of two output rates: one pulse per line, or one pulse per half line. The host also sets a 6-bit phase word that places the pulse within its period, and a flip bit that moves the pulse by half of the output period (180 degrees).

The block also watches two inputs. Incoming horizontal sync edges are compared with the internal line position. A run of disagreements marks the timing as out of lock, and a later run of agreements marks it as locked again. The flyback input is watched for edges. When no edge arrives for two line periods, a warning is raised. Both warnings are sticky until the host clears them. A loop-mode select bit is passed through one register. It chooses between normal and tape-source gain and time constant for the external loop filter.

The sync and flyback inputs are assumed to be synchronous to the clock.

Top module: `hdrive_gen`

## Requirements
- R1: After reset, the 7-bit line position starts at 0 and advances by one each clock. It wraps from 127 to 0, so a line is 128 clocks and a half line is 64 clocks.
- R2: With rate_2x=0 and flip_180=0, hdrive_out is high for PULSE_W (8) consecutive line positions, starting at line position phase_word. The window wraps past 127. The output is registered, so it reflects the line position of the previous clock.
- R3: With rate_2x=1, the pulse repeats every 64 positions. It is high when the low 6 bits of the line position, minus the start, modulo 64, is less than PULSE_W. With flip_180=0, the start is phase_word.
- R4: With flip_180=1, the start moves by half of the output period. In 1x mode the start becomes phase_word+64, modulo 128. In 2x mode it becomes phase_word+32, modulo 64.
- R5: A rising edge of hsync_in is a hit when the line position at that clock is within 2 of 0 (positions 126, 127, 0, 1, 2). Any other position is a miss.
- R6: unlocked goes high after 4 consecutive misses. Fewer than 4 misses, or a hit between misses, leaves it low.
- R7: While unlocked is high, 4 consecutive hits return it to low. Fewer than 4 hits leave it high.
- R8: lock_lost goes high together with unlocked. It stays high after unlocked returns low, until a clr_flags pulse clears it.
- R9: flyback_missing goes high once 256 clocks (2 lines) pass with no rising edge on flyback_in. It stays low while edges arrive every line.
- R10: flyback_missing is sticky. clr_flags clears it only once flyback edges have resumed. While flyback is still absent, the flag stays high through a clear.
- R11: loop_tape equals tape_mode as it was one clock earlier.
- R12: While rst_n is low, hdrive_out, loop_tape, unlocked, lock_lost and flyback_missing are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_word | input | 6 | Pulse start within the output period |
| flip_180 | input | 1 | Shift the pulse by half the output period |
| rate_2x | input | 1 | 1: pulse every half line, 0: pulse every line |
| tape_mode | input | 1 | Loop mode select: 1 tape source, 0 normal |
| clr_flags | input | 1 | Clear the sticky warning flags |
| hsync_in | input | 1 | Incoming horizontal sync |
| flyback_in | input | 1 | Flyback pulse from the output stage |
| hdrive_out | output | 1 | Horizontal drive pulse |
| loop_tape | output | 1 | Registered loop mode select |
| unlocked | output | 1 | Live out-of-lock status with hysteresis |
| lock_lost | output | 1 | Sticky lock-loss warning |
| flyback_missing | output | 1 | Sticky missing-flyback warning |

## Verification
A line counter that slips or resets early shows up within one line as drive pulses at the wrong positions. It also makes a sync sent at a known position land as a miss. A wrong hit or miss count is only visible at the fourth sync. The bench therefore checks the flag right after the third and the fourth edge, and after a run that a hit breaks. A flyback timer that starts late or saturates wrong moves the flag edge in time. The flag is sampled at a point before the 256-clock window closes and at a point after it.

// File: rtl/hdg_pkg.sv
// Package: shared helpers for the horizontal drive generator.
// Assumes: callers pass positions of equal width.
package hdg_pkg;

    // Classification of one sync edge against the internal line timing.
    typedef enum logic {
        SYNC_HIT  = 1'b0,
        SYNC_MISS = 1'b1
    } sync_class_t;

endpackage

// File: rtl/hdg_linecnt.sv
// Line position counter. It counts one line as two halves, so it carries
// both the twice-line-rate phase (low bits) and the half index (top bit).
// Assumes: a line is 2**LPOS_W clocks.
module hdg_linecnt #(
    parameter int LPOS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LPOS_W-1:0] lpos
);

    // Advance the line position by one every clock, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) lpos <= '0;
        else        lpos <= lpos + 1'b1;
    end

endmodule

// File: rtl/hdg_drive.sv
// Drive pulse generator. It builds a registered pulse of PULSE_W counts
// from the line position, the phase word, the flip bit and the rate select.
// Assumes: PULSE_W < 2**PH_W.
module hdg_drive #(
    parameter int PH_W    = 6,
    parameter int PULSE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PH_W:0] lpos,
    input  logic [PH_W-1:0] phase_word,
    input  logic          flip_180,
    input  logic          rate_2x,
    output logic          hdrive_out
);

    localparam int LPOS_W = PH_W + 1;

    logic [LPOS_W-1:0] start_1x;
    logic [PH_W-1:0]   start_2x;
    logic [LPOS_W-1:0] dist_1x;
    logic [PH_W-1:0]   dist_2x;
    logic              on_1x;
    logic              on_2x;

    // Pulse start and distance into the window for both output rates.
    always_comb begin
        start_1x = {flip_180, phase_word};
        start_2x = phase_word + {flip_180, {(PH_W-1){1'b0}}};
        dist_1x  = lpos - start_1x;
        dist_2x  = lpos[PH_W-1:0] - start_2x;
        on_1x    = dist_1x < LPOS_W'(PULSE_W);
        on_2x    = dist_2x < PH_W'(PULSE_W);
    end

    // Register the selected pulse so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) hdrive_out <= 1'b0;
        else        hdrive_out <= rate_2x ? on_2x : on_1x;
    end

endmodule

// File: rtl/hdg_coinc.sv
// Coincidence supervisor. It classifies each rising sync edge against the
// line position and keeps a lock status with miss/hit hysteresis, plus a
// sticky lock-loss flag.
// Assumes: hsync_in is synchronous to clk; expected sync is at position 0.
module hdg_coinc
    import hdg_pkg::*;
#(
    parameter int LPOS_W = 7,
    parameter int TOL    = 2,
    parameter int MISS_N = 4,
    parameter int HIT_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LPOS_W-1:0] lpos,
    input  logic              hsync_in,
    input  logic              clr_flags,
    output logic              unlocked,
    output logic              lock_lost
);

    localparam int RUN_MAX = (MISS_N > HIT_N) ? MISS_N : HIT_N;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic             hs_q;
    logic             hs_rise;
    sync_class_t      cls;
    logic [RUN_W-1:0] miss_run;
    logic [RUN_W-1:0] hit_run;
    logic             lose_now;
    logic             regain_now;

    // Previous sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hsync_in;
    end

    // Edge detect, window classification and hysteresis decisions.
    always_comb begin
        hs_rise    = hsync_in & ~hs_q;
        cls        = ((lpos <= LPOS_W'(TOL)) || (lpos >= LPOS_W'(2**LPOS_W - TOL)))
                     ? SYNC_HIT : SYNC_MISS;
        lose_now   = hs_rise && (cls == SYNC_MISS) && !unlocked
                     && (miss_run == RUN_W'(MISS_N - 1));
        regain_now = hs_rise && (cls == SYNC_HIT) && unlocked
                     && (hit_run == RUN_W'(HIT_N - 1));
    end

    // Consecutive miss and hit run counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_run <= '0;
            hit_run  <= '0;
        end else if (hs_rise) begin
            if (cls == SYNC_HIT) begin
                miss_run <= '0;
                hit_run  <= (unlocked && !regain_now) ? hit_run + 1'b1 : '0;
            end else begin
                hit_run  <= '0;
                miss_run <= (!unlocked && !lose_now) ? miss_run + 1'b1 : '0;
            end
        end
    end

    // Live lock status with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)          unlocked <= 1'b0;
        else if (lose_now)   unlocked <= 1'b1;
        else if (regain_now) unlocked <= 1'b0;
    end

    // Sticky lock-loss flag; a new loss wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_lost <= 1'b0;
        else        lock_lost <= lose_now | (lock_lost & ~clr_flags);
    end

endmodule

// File: rtl/hdg_flyback.sv
// Flyback presence supervisor. It times the gap since the last flyback
// edge and raises a sticky flag when the gap reaches FB_LIMIT clocks.
// Assumes: flyback_in is synchronous to clk.
module hdg_flyback #(
    parameter int FB_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flyback_in,
    input  logic clr_flags,
    output logic flyback_missing
);

    localparam int GAP_W = $clog2(FB_LIMIT + 1);

    logic             fb_q;
    logic             fb_rise;
    logic [GAP_W-1:0] gap;
    logic             gap_full;

    // Previous flyback level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= 1'b0;
        else        fb_q <= flyback_in;
    end

    // Edge and window-expired decode.
    always_comb begin
        fb_rise  = flyback_in & ~fb_q;
        gap_full = (gap == GAP_W'(FB_LIMIT));
    end

    // Saturating gap timer, restarted by each flyback edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         gap <= '0;
        else if (fb_rise)   gap <= '0;
        else if (!gap_full) gap <= gap + 1'b1;
    end

    // Sticky warning; an expired window keeps it set through a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flyback_missing <= 1'b0;
        else        flyback_missing <= gap_full | (flyback_missing & ~clr_flags);
    end

endmodule

// File: rtl/hdrive_gen.sv
// Top of the horizontal drive generator. It wires the line counter, the
// drive pulse generator, the coincidence supervisor and the flyback
// supervisor, and registers the loop-mode select.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module hdrive_gen #(
    parameter int PH_W     = 6,
    parameter int PULSE_W  = 8,
    parameter int TOL      = 2,
    parameter int MISS_N   = 4,
    parameter int HIT_N    = 4,
    parameter int FB_LINES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase_word,
    input  logic            flip_180,
    input  logic            rate_2x,
    input  logic            tape_mode,
    input  logic            clr_flags,
    input  logic            hsync_in,
    input  logic            flyback_in,
    output logic            hdrive_out,
    output logic            loop_tape,
    output logic            unlocked,
    output logic            lock_lost,
    output logic            flyback_missing
);

    localparam int LPOS_W   = PH_W + 1;
    localparam int LINE_LEN = 2 ** LPOS_W;
    localparam int FB_LIMIT = FB_LINES * LINE_LEN;

    logic [LPOS_W-1:0] lpos;

    hdg_linecnt #(.LPOS_W(LPOS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .lpos  (lpos)
    );

    hdg_drive #(.PH_W(PH_W), .PULSE_W(PULSE_W)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .lpos       (lpos),
        .phase_word (phase_word),
        .flip_180   (flip_180),
        .rate_2x    (rate_2x),
        .hdrive_out (hdrive_out)
    );

    hdg_coinc #(.LPOS_W(LPOS_W), .TOL(TOL), .MISS_N(MISS_N), .HIT_N(HIT_N)) u_coi (
        .clk       (clk),
        .rst_n     (rst_n),
        .lpos      (lpos),
        .hsync_in  (hsync_in),
        .clr_flags (clr_flags),
        .unlocked  (unlocked),
        .lock_lost (lock_lost)
    );

    hdg_flyback #(.FB_LIMIT(FB_LIMIT)) u_fly (
        .clk             (clk),
        .rst_n           (rst_n),
        .flyback_in      (flyback_in),
        .clr_flags       (clr_flags),
        .flyback_missing (flyback_missing)
    );

    // Register the loop-mode select for the external loop filter.
    always_ff @(posedge clk) begin
        if (!rst_n) loop_tape <= 1'b0;
        else        loop_tape <= tape_mode;
    end

endmodule

// File: rtl/hdrive_gen_chk.sv
// Checker for hdrive_gen: port-level temporal properties, bound to the top.
// Assumes: the same clock and reset as the bound instance.
module hdrive_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tape_mode,
    input logic clr_flags,
    input logic loop_tape,
    input logic unlocked,
    input logic lock_lost,
    input logic flyback_missing
);

    // R11
    loop_mode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (loop_tape == $past(tape_mode)));

    // R8
    lock_flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_lost) |-> $rose(unlocked));

    // R8
    lock_flag_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> lock_lost);

    // R8
    lock_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_lost) |-> $past(clr_flags));

    // R10
    flyback_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flyback_missing) |-> $past(clr_flags));

endmodule

bind hdrive_gen hdrive_gen_chk u_chk (.*);

// File: tb/sim_hdrive_gen.sv
`timescale 1ns/1ps
module sim_hdrive_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] phase_word = 6'd10;
    logic       flip_180 = 1'b0;
    logic       rate_2x = 1'b0;
    logic       tape_mode = 1'b0;
    logic       clr_flags = 1'b0;
    logic       hsync_in = 1'b0;
    logic       flyback_in;
    logic       hdrive_out, loop_tape, unlocked, lock_lost, flyback_missing;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hdrive_gen u0 (
        .clk(clk), .rst_n(rst_n), .phase_word(phase_word), .flip_180(flip_180),
        .rate_2x(rate_2x), .tape_mode(tape_mode), .clr_flags(clr_flags),
        .hsync_in(hsync_in), .flyback_in(flyback_in), .hdrive_out(hdrive_out),
        .loop_tape(loop_tape), .unlocked(unlocked), .lock_lost(lock_lost),
        .flyback_missing(flyback_missing)
    );

    // Line position model from R1.
    logic [6:0] m;
    always @(posedge clk) begin
        if (!rst_n) m <= 7'd0;
        else        m <= m + 7'd1;
    end

    // Flyback source: one 4-clock pulse every 128 clocks while enabled.
    bit         fb_en = 1'b1;
    logic [6:0] fb_ph = 7'd0;
    always @(negedge clk) fb_ph <= fb_ph + 7'd1;
    assign flyback_in = fb_en && (fb_ph < 7'd4);

    // Drive vectors: {rate_2x, flip_180, phase_word, expected start}.
    localparam int NV = 7;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 6'd10, 7'd10},
        {1'b0, 1'b1, 6'd10, 7'd74},
        {1'b1, 1'b0, 6'd10, 7'd10},
        {1'b1, 1'b1, 6'd10, 7'd42},
        {1'b0, 1'b0, 6'd62, 7'd62},
        {1'b1, 1'b1, 6'd40, 7'd8},
        {1'b0, 1'b1, 6'd63, 7'd127}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send one sync rising edge at line position p (R5).
    task automatic send_sync(input logic [6:0] p);
        repeat (10) @(negedge clk);
        while (m != p) @(negedge clk);
        hsync_in = 1'b1;
        repeat (2) @(negedge clk);
        hsync_in = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) clr_flags = 1'b1;
        @(negedge clk) clr_flags = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check({hdrive_out, loop_tape, unlocked, lock_lost, flyback_missing} == 5'd0,
              "R12 outputs low in reset",
              int'({hdrive_out, loop_tape, unlocked, lock_lost, flyback_missing}), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 drive vectors
        for (int v = 0; v < NV; v++) begin
            int bad = 0;
            int bad_l = 0;
            int per;
            int s;
            @(negedge clk);
            rate_2x    = VEC[v][14];
            flip_180   = VEC[v][13];
            phase_word = VEC[v][12:7];
            per = rate_2x ? 64 : 128;
            s   = int'(VEC[v][6:0]) % per;
            repeat (140) @(negedge clk);
            for (int k = 0; k < 128; k++) begin
                int l;
                bit e;
                l = (int'(m) + 127) % 128;
                e = (((l - s) % per + per) % per) < 8;
                if (hdrive_out !== e && bad == 0) bad_l = l;
                if (hdrive_out !== e) bad++;
                @(negedge clk);
            end
            check(bad == 0, $sformatf("R2 R3 R4 drive vector %0d first bad pos %0d", v, bad_l),
                  bad, 0);
        end
        rate_2x = 1'b0; flip_180 = 1'b0;

        // R11 loop mode select
        @(negedge clk) tape_mode = 1'b1;
        @(negedge clk);
        check(loop_tape == 1'b1, "R11 loop_tape set", loop_tape, 1);
        tape_mode = 1'b0;
        @(negedge clk);
        check(loop_tape == 1'b0, "R11 loop_tape clear", loop_tape, 0);

        // R5 R6 misses at tolerance edge +-3, broken by a hit
        send_sync(7'd3); send_sync(7'd125); send_sync(7'd3);
        @(negedge clk);
        check(unlocked == 1'b0, "R6 three misses keep lock", unlocked, 0);
        send_sync(7'd0);
        send_sync(7'd5); send_sync(7'd5); send_sync(7'd5);
        @(negedge clk);
        check(unlocked == 1'b0, "R6 hit restarts miss run", unlocked, 0);
        send_sync(7'd5);
        @(negedge clk);
        check(unlocked == 1'b1, "R6 fourth miss unlocks", unlocked, 1);
        check(lock_lost == 1'b1, "R8 lock_lost with unlock", lock_lost, 1);

        // R5 R7 hits at window edges
        send_sync(7'd126); send_sync(7'd2); send_sync(7'd1);
        @(negedge clk);
        check(unlocked == 1'b1, "R7 three hits stay unlocked", unlocked, 1);
        send_sync(7'd0);
        @(negedge clk);
        check(unlocked == 1'b0, "R7 fourth hit relocks", unlocked, 0);
        check(lock_lost == 1'b1, "R8 lock_lost sticky", lock_lost, 1);
        pulse_clear();
        check(lock_lost == 1'b0, "R8 lock_lost cleared", lock_lost, 0);

        // R9 flyback present then removed
        check(flyback_missing == 1'b0, "R9 no flag with flyback", flyback_missing, 0);
        while (fb_ph != 7'd10) @(negedge clk);
        fb_en = 1'b0;
        repeat (200) @(negedge clk);
        check(flyback_missing == 1'b0, "R9 flag low before 2 lines", flyback_missing, 0);
        repeat (100) @(negedge clk);
        check(flyback_missing == 1'b1, "R9 flag high after 2 lines", flyback_missing, 1);

        // R10 clear while absent, then after flyback resumes
        pulse_clear();
        check(flyback_missing == 1'b1, "R10 flag persists while absent", flyback_missing, 1);
        fb_en = 1'b1;
        repeat (300) @(negedge clk);
        check(flyback_missing == 1'b1, "R10 flag sticky after return", flyback_missing, 1);
        pulse_clear();
        check(flyback_missing == 1'b0, "R10 flag cleared", flyback_missing, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule